// File: doc/BRIEF.md
# Replication-Aware Victim Selector

This block decides which way of one last-level cache set gives up its line when a new line must be installed. It is meant for a tile of a many-core chip where the same line may be cached in several tiles at once. It keeps the valid bits, LRU ages and reference bits of the set itself. On each fill, the caller also presents per-way facts that come from elsewhere: the block address of each resident line, whether it is a duplicate copy, whether it is dirty, and how many tiles share it.

On a fill the block returns the chosen way and what must happen to the line leaving it: nothing (the way was empty), a silent drop, a spill to the line's home tile, or a write-back off chip. It also returns the home tile of the evicted line. A hit request marks the way as referenced and most recently used. Duplicates that nobody has touched recently are given up first, so that more unique lines stay on chip.

The control is a two-state machine. `ST_IDLE` accepts a request; the transition *accept* (`req_valid` with `req_ready`) computes and registers the decision and moves to `ST_RESP`. `ST_RESP` presents the decision; the transition *release* (`rsp_ready` high) returns to `ST_IDLE`.

Top module: `rvs_top`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, every way is invalid and way i has LRU age i, where age 0 is most recently used.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `rsp_valid` is 1 in the next cycle, and `req_ready` stays 0 while `rsp_valid` is 1. The response values hold steady until a cycle with `rsp_ready` high ends it.
- R3: On a fill, if any way is invalid, the lowest-numbered invalid way is chosen with action NONE (code 0) and `rsp_home` 0.
- R4: On a fill with every way valid, the chosen way is the one with the largest age among ways whose `way_replica` bit is 1 and whose reference bit is clear, if such a way exists.
- R5: Otherwise the chosen way is the valid way with the largest age.
- R6: An evicted line with a sharer count of 2 or more gets DROP (code 1) when clean and WRITEBACK (code 3) when dirty.
- R7: An evicted line with a sharer count of 0 or 1 whose home tile differs from `local_tile` gets SPILL (code 2).
- R8: An evicted line with a sharer count of 0 or 1 whose home tile equals `local_tile` gets WRITEBACK (code 3) when dirty and DROP (code 1) when clean.
- R9: The home tile is the XOR of the consecutive log2(TILES)-bit chunks of address bits [ADDR_W-1:6], taken from bit 6 upward, with the last chunk zero-padded. `rsp_home` carries it for every evicting fill.
- R10: After a fill the chosen way is valid, has age 0 and a clear reference bit. Every way younger than its old age ages by one.
- R11: A hit on way `req_way` responds with that way, action NONE and home 0. It sets that way's reference bit and makes it most recently used, with the same aging as R10.
- R12: If a hit leaves every valid way with its reference bit set, all reference bits except the hit way's are cleared.
- R13: The ages of the ways always form a permutation of 0 to WAYS-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block can take a request |
| req_fill | input | 1 | 1 = fill (select victim), 0 = hit |
| req_way | input | log2(WAYS) | Way hit by a hit request |
| local_tile | input | log2(TILES) | Index of this tile |
| way_addr | input | WAYS*ADDR_W | Block address of each resident line, way 0 in the low bits |
| way_replica | input | WAYS | Line in the way is a duplicate copy |
| way_dirty | input | WAYS | Line in the way is modified |
| way_sharers | input | WAYS*SHR_W | On-chip copy count of each resident line |
| rsp_valid | output | 1 | Decision available |
| rsp_ready | input | 1 | Consumer takes the decision |
| rsp_way | output | log2(WAYS) | Chosen or hit way |
| rsp_action | output | 2 | 0 NONE, 1 DROP, 2 SPILL, 3 WRITEBACK |
| rsp_home | output | log2(TILES) | Home tile of the evicted line |

## Verification
The assertions assume that a hit only names a way the caller knows to be valid. They also assume that `local_tile` and the per-way inputs stay steady while a response waits, because the spill check compares the registered home against the live `local_tile`. The bench keeps to these assumptions: it takes hit ways from its own model's valid set and changes inputs only in `ST_IDLE`. Random stimulus sets `local_tile` to the predicted victim's home about a third of the time, so that the home-local outcomes are reached, and it draws sharer counts mostly from 0 to 3 so that single-copy and shared lines both occur.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_DROP  = 2'd1,
        ACT_SPILL = 2'd2,
        ACT_WRBK  = 2'd3
    } rvs_action_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rvs_state_e;

endpackage

// File: rtl/rvs_home_hash.sv
module rvs_home_hash #(
    parameter int ADDR_W = 40,
    parameter int OFF_W  = 6,
    parameter int TILES  = 64
) (
    input  logic [ADDR_W-1:0]         addr,
    output logic [$clog2(TILES)-1:0]  home
);
    localparam int TILE_W = $clog2(TILES);
    localparam int SPAN   = ADDR_W - OFF_W;
    localparam int CHUNKS = (SPAN + TILE_W - 1) / TILE_W;

    logic [CHUNKS*TILE_W-1:0] padded;
    logic [TILE_W-1:0]        acc [CHUNKS+1];

    always_comb begin
        padded = '0;
        padded[SPAN-1:0] = addr[ADDR_W-1:OFF_W];
    end

    assign acc[0] = '0;
    for (genvar k = 0; k < CHUNKS; k++) begin : g_fold
        assign acc[k+1] = acc[k] ^ padded[k*TILE_W +: TILE_W];
    end

    assign home = acc[CHUNKS];
endmodule

// File: rtl/rvs_victim_pick.sv
module rvs_victim_pick #(
    parameter int WAYS = 8
) (
    input  logic [WAYS-1:0]                    valid,
    input  logic [WAYS-1:0]                    refd,
    input  logic [WAYS-1:0]                    replica,
    input  logic [WAYS-1:0][$clog2(WAYS)-1:0]  age,
    output logic [$clog2(WAYS)-1:0]            victim,
    output logic                               victim_empty
);
    localparam int WAY_W = $clog2(WAYS);

    logic             have_inv, have_idle, have_old;
    logic [WAY_W-1:0] inv_way, idle_way, old_way;
    logic [WAY_W-1:0] idle_age, old_age;

    always_comb begin
        have_inv  = 1'b0;
        inv_way   = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                have_inv = 1'b1;
                inv_way  = WAY_W'(i);
            end
        end

        have_idle = 1'b0;
        idle_way  = '0;
        idle_age  = '0;
        have_old  = 1'b0;
        old_way   = '0;
        old_age   = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (valid[i] && replica[i] && !refd[i] &&
                (!have_idle || age[i] > idle_age)) begin
                have_idle = 1'b1;
                idle_way  = WAY_W'(i);
                idle_age  = age[i];
            end
            if (valid[i] && (!have_old || age[i] > old_age)) begin
                have_old = 1'b1;
                old_way  = WAY_W'(i);
                old_age  = age[i];
            end
        end

        victim_empty = have_inv;
        if (have_inv)       victim = inv_way;
        else if (have_idle) victim = idle_way;
        else                victim = old_way;
    end
endmodule

// File: rtl/rvs_set_state.sv
module rvs_set_state #(
    parameter int WAYS = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               upd_en,
    input  logic                               upd_fill,
    input  logic [$clog2(WAYS)-1:0]            upd_way,
    output logic [WAYS-1:0]                    valid_q,
    output logic [WAYS-1:0]                    ref_q,
    output logic [WAYS-1:0][$clog2(WAYS)-1:0]  age_q
);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAYS-1:0]             valid_n, ref_n, ref_tmp;
    logic [WAYS-1:0][WAY_W-1:0]  age_n;
    logic [WAY_W-1:0]            pivot;

    always_comb begin
        valid_n = valid_q;
        ref_n   = ref_q;
        age_n   = age_q;
        ref_tmp = ref_q;
        pivot   = age_q[upd_way];
        if (upd_en) begin
            for (int i = 0; i < WAYS; i++) begin
                if (WAY_W'(i) == upd_way)   age_n[i] = '0;
                else if (age_q[i] < pivot)  age_n[i] = age_q[i] + 1'b1;
            end
            if (upd_fill) begin
                valid_n[upd_way] = 1'b1;
                ref_n[upd_way]   = 1'b0;
            end else begin
                ref_tmp[upd_way] = 1'b1;
                if (&(ref_tmp | ~valid_q)) begin
                    ref_n          = '0;
                    ref_n[upd_way] = 1'b1;
                end else begin
                    ref_n = ref_tmp;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ref_q   <= '0;
            for (int i = 0; i < WAYS; i++) age_q[i] <= WAY_W'(i);
        end else begin
            valid_q <= valid_n;
            ref_q   <= ref_n;
            age_q   <= age_n;
        end
    end
endmodule

// File: rtl/rvs_top.sv
module rvs_top
    import rvs_pkg::*;
#(
    parameter int WAYS   = 8,
    parameter int TILES  = 64,
    parameter int ADDR_W = 40,
    parameter int OFF_W  = 6,
    parameter int SHR_W  = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_fill,
    input  logic [$clog2(WAYS)-1:0]   req_way,
    input  logic [$clog2(TILES)-1:0]  local_tile,
    input  logic [WAYS*ADDR_W-1:0]    way_addr,
    input  logic [WAYS-1:0]           way_replica,
    input  logic [WAYS-1:0]           way_dirty,
    input  logic [WAYS*SHR_W-1:0]     way_sharers,
    output logic                      rsp_valid,
    input  logic                      rsp_ready,
    output logic [$clog2(WAYS)-1:0]   rsp_way,
    output logic [1:0]                rsp_action,
    output logic [$clog2(TILES)-1:0]  rsp_home
);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TILE_W = $clog2(TILES);

    rvs_state_e state_q, state_n;
    logic       accept;

    logic [WAYS-1:0]             set_valid, set_ref;
    logic [WAYS-1:0][WAY_W-1:0]  set_age;
    logic [WAY_W-1:0]            vic_way, upd_way;
    logic                        vic_empty;
    logic [ADDR_W-1:0]           vic_addr;
    logic [SHR_W-1:0]            vic_shr;
    logic                        vic_dirty;
    logic [TILE_W-1:0]           vic_home;
    rvs_action_e                 fill_act;

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = (state_q == ST_RESP);
    assign upd_way   = req_fill ? vic_way : req_way;

    rvs_set_state #(.WAYS(WAYS)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (accept),
        .upd_fill (req_fill),
        .upd_way  (upd_way),
        .valid_q  (set_valid),
        .ref_q    (set_ref),
        .age_q    (set_age)
    );

    rvs_victim_pick #(.WAYS(WAYS)) u_pick (
        .valid        (set_valid),
        .refd         (set_ref),
        .replica      (way_replica),
        .age          (set_age),
        .victim       (vic_way),
        .victim_empty (vic_empty)
    );

    assign vic_addr  = way_addr[vic_way*ADDR_W +: ADDR_W];
    assign vic_shr   = way_sharers[vic_way*SHR_W +: SHR_W];
    assign vic_dirty = way_dirty[vic_way];

    rvs_home_hash #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .TILES(TILES)) u_hash (
        .addr (vic_addr),
        .home (vic_home)
    );

    always_comb begin
        if (vic_empty)
            fill_act = ACT_NONE;
        else if (vic_shr > SHR_W'(1))
            fill_act = vic_dirty ? ACT_WRBK : ACT_DROP;
        else if (vic_home != local_tile)
            fill_act = ACT_SPILL;
        else
            fill_act = vic_dirty ? ACT_WRBK : ACT_DROP;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)    state_n = ST_RESP;
            ST_RESP: if (rsp_ready) state_n = ST_IDLE;
            default:                state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_way    <= '0;
            rsp_action <= ACT_NONE;
            rsp_home   <= '0;
        end else if (accept) begin
            if (req_fill) begin
                rsp_way    <= vic_way;
                rsp_action <= fill_act;
                rsp_home   <= vic_empty ? '0 : vic_home;
            end else begin
                rsp_way    <= req_way;
                rsp_action <= ACT_NONE;
                rsp_home   <= '0;
            end
        end
    end
endmodule

// File: rtl/rvs_chk.sv
module rvs_chk #(
    parameter int WAYS  = 8,
    parameter int TILES = 64
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               req_valid,
    input logic                               req_ready,
    input logic                               req_fill,
    input logic [$clog2(WAYS)-1:0]            req_way,
    input logic [$clog2(TILES)-1:0]           local_tile,
    input logic                               rsp_valid,
    input logic                               rsp_ready,
    input logic [$clog2(WAYS)-1:0]            rsp_way,
    input logic [1:0]                         rsp_action,
    input logic [$clog2(TILES)-1:0]           rsp_home,
    input logic [WAYS-1:0]                    set_valid,
    input logic [WAYS-1:0]                    set_ref,
    input logic [WAYS-1:0][$clog2(WAYS)-1:0]  set_age
);
    logic            took;
    logic [WAYS-1:0] seen;

    assign took = req_valid && req_ready;

    always_comb begin
        seen = '0;
        for (int i = 0; i < WAYS; i++) seen[set_age[i]] = 1'b1;
    end

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        took |=> rsp_valid);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && !req_ready &&
        $stable(rsp_way) && $stable(rsp_action) && $stable(rsp_home));

    // R3
    empty_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        took && req_fill && !(&set_valid) |=> rsp_action == 2'd0);

    // R10
    fill_install_chk: assert property (@(posedge clk) disable iff (!rst_n)
        took && req_fill |=> set_valid[rsp_way] && set_age[rsp_way] == '0 && !set_ref[rsp_way]);

    // R11
    hit_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        took && !req_fill |=> rsp_action == 2'd0 && rsp_way == $past(req_way) &&
        set_ref[rsp_way] && set_age[rsp_way] == '0);

    // R7
    spill_remote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_action == 2'd2 |-> rsp_home != local_tile);

    // R13
    age_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        &seen);
endmodule

bind rvs_top rvs_chk #(.WAYS(WAYS), .TILES(TILES)) u_rvs_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_fill   (req_fill),
    .req_way    (req_way),
    .local_tile (local_tile),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_way    (rsp_way),
    .rsp_action (rsp_action),
    .rsp_home   (rsp_home),
    .set_valid  (set_valid),
    .set_ref    (set_ref),
    .set_age    (set_age)
);

// File: tb/tb_rvs_top.sv
module tb_rvs_top;
    localparam int WAYS   = 8;
    localparam int TILES  = 64;
    localparam int ADDR_W = 40;
    localparam int OFF_W  = 6;
    localparam int SHR_W  = 7;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TILE_W = $clog2(TILES);

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   req_valid = 1'b0;
    logic                   req_ready;
    logic                   req_fill = 1'b0;
    logic [WAY_W-1:0]       req_way = '0;
    logic [TILE_W-1:0]      local_tile = '0;
    logic [WAYS*ADDR_W-1:0] way_addr = '0;
    logic [WAYS-1:0]        way_replica = '0;
    logic [WAYS-1:0]        way_dirty = '0;
    logic [WAYS*SHR_W-1:0]  way_sharers = '0;
    logic                   rsp_valid;
    logic                   rsp_ready = 1'b0;
    logic [WAY_W-1:0]       rsp_way;
    logic [1:0]             rsp_action;
    logic [TILE_W-1:0]      rsp_home;

    int vectors = 0;
    int errors  = 0;

    bit m_valid [WAYS];
    bit m_ref   [WAYS];
    int m_age   [WAYS];

    always #2.5 clk = ~clk;

    rvs_top #(.WAYS(WAYS), .TILES(TILES), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SHR_W(SHR_W)) dut (
        .clk, .rst_n, .req_valid, .req_ready, .req_fill, .req_way, .local_tile,
        .way_addr, .way_replica, .way_dirty, .way_sharers,
        .rsp_valid, .rsp_ready, .rsp_way, .rsp_action, .rsp_home
    );

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R9 fold of address chunks
    function automatic int home_of(logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] blk = a >> OFF_W;
        int h = 0;
        for (int k = 0; k * TILE_W < ADDR_W - OFF_W; k++)
            h ^= int'((blk >> (k * TILE_W)) & ((1 << TILE_W) - 1));
        return h;
    endfunction

    function automatic int pick_victim(output bit empty);
        int best = -1;
        empty = 0;
        for (int i = 0; i < WAYS; i++)
            if (!m_valid[i]) begin empty = 1; return i; end
        for (int i = 0; i < WAYS; i++)
            if (way_replica[i] && !m_ref[i] && (best < 0 || m_age[i] > m_age[best])) best = i;
        if (best >= 0) return best;
        for (int i = 0; i < WAYS; i++)
            if (best < 0 || m_age[i] > m_age[best]) best = i;
        return best;
    endfunction

    function automatic void touch(int w);
        int piv = m_age[w];
        for (int i = 0; i < WAYS; i++) begin
            if (i == w)            m_age[i] = 0;
            else if (m_age[i] < piv) m_age[i]++;
        end
    endfunction

    task automatic randomize_ways();
        for (int i = 0; i < WAYS; i++) begin
            way_addr[i*ADDR_W +: ADDR_W] = {$urandom(), $urandom()};
            way_replica[i] = $urandom_range(0, 1);
            way_dirty[i]   = $urandom_range(0, 1);
            way_sharers[i*SHR_W +: SHR_W] = ($urandom_range(0, 9) == 0) ?
                SHR_W'($urandom_range(4, 100)) : SHR_W'($urandom_range(0, 3));
        end
    endtask

    task automatic transact(bit fill, int hway, bit home_local);
        int  ew, ea, eh, shr, hold;
        bit  emp, allset;
        string t;
        req_fill = fill;
        req_way  = WAY_W'(hway);
        if (fill) begin
            ew = pick_victim(emp);
            eh = emp ? 0 : home_of(way_addr[ew*ADDR_W +: ADDR_W]);
            local_tile = home_local ? TILE_W'(eh) : TILE_W'($urandom_range(0, TILES-1));
            shr = int'(way_sharers[ew*SHR_W +: SHR_W]);
            if (emp)                         begin ea = 0; t = "R3"; end
            else if (shr >= 2)               begin ea = way_dirty[ew] ? 3 : 1; t = "R6"; end
            else if (eh != int'(local_tile)) begin ea = 2; t = "R7"; end
            else                             begin ea = way_dirty[ew] ? 3 : 1; t = "R8"; end
        end else begin
            ew = hway; ea = 0; eh = 0; t = "R11";
        end
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 rsp_valid", int'(rsp_valid), 1);
        chk(fill ? "R4/R5 way" : "R11 way", int'(rsp_way), ew);
        chk({t, " action"}, int'(rsp_action), ea);
        chk("R9 home", int'(rsp_home), eh);
        // model update (R10 R11 R12)
        touch(ew);
        if (fill) begin
            m_valid[ew] = 1; m_ref[ew] = 0;
        end else begin
            m_ref[ew] = 1;
            allset = 1;
            for (int i = 0; i < WAYS; i++) if (m_valid[i] && !m_ref[i]) allset = 0;
            if (allset) for (int i = 0; i < WAYS; i++) m_ref[i] = (i == ew);
        end
        hold = $urandom_range(0, 2);
        for (int c = 0; c < hold; c++) begin
            @(negedge clk);
            chk("R2 hold valid", int'(rsp_valid), 1);
            chk("R2 hold way", int'(rsp_way), ew);
            chk("R2 ready low", int'(req_ready), 0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R2 released", int'(req_ready), 1);
    endtask

    function automatic int pick_valid_way();
        int w;
        do w = $urandom_range(0, WAYS-1); while (!m_valid[w]);
        return w;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < WAYS; i++) begin m_valid[i] = 0; m_ref[i] = 0; m_age[i] = i; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 req_ready", int'(req_ready), 1);
        chk("R1 rsp_valid", int'(rsp_valid), 0);
        // R1 R3: fill empty set, lowest invalid first
        for (int i = 0; i < WAYS; i++) begin
            randomize_ways();
            transact(1'b1, 0, 1'b0);
        end
        // R12: hit every way in turn, last hit clears the others
        for (int i = 0; i < WAYS; i++) transact(1'b0, i, 1'b0);
        // R4: all duplicates, unreferenced ones preferred
        randomize_ways();
        way_replica = '1;
        transact(1'b1, 0, 1'b0);
        // R5: no duplicates, plain LRU
        randomize_ways();
        way_replica = '0;
        transact(1'b1, 0, 1'b0);
        // R8: single copy at home, clean and dirty
        randomize_ways();
        way_sharers = '0;
        way_dirty = '0;
        transact(1'b1, 0, 1'b1);
        randomize_ways();
        for (int i = 0; i < WAYS; i++) way_sharers[i*SHR_W +: SHR_W] = SHR_W'(1);
        way_dirty = '1;
        transact(1'b1, 0, 1'b1);
        // R7: single copy away from home
        randomize_ways();
        way_sharers = '0;
        transact(1'b1, 0, 1'b0);
        // random mix (R4 R5 R6 R7 R8 R10 R11 R12 R13)
        for (int n = 0; n < 400; n++) begin
            randomize_ways();
            if ($urandom_range(0, 1) == 0) transact(1'b0, pick_valid_way(), 1'b0);
            else transact(1'b1, 0, $urandom_range(0, 2) == 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule